// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers the interrupt conditions of one serial channel and reports the most urgent one. It takes seven sources: line-status error, receive data at trigger level, receive time-out, transmit holding register empty, modem status change, software flow control (received Xoff or matched special character) and hardware flow control (rising CTS input or rising RTS output). An 8-bit enable register masks them. A combinational priority encoder picks the single highest pending source, and that choice appears as a status byte. An interrupt line goes high whenever some enabled source is pending and the output gate from modem control is on.

Line-status, receive and modem conditions are levels. They are owned by their producers and pass straight through. The transmit-empty, software flow and hardware flow conditions are events, and this block latches them. A status read that reports a latched source clears it. A holding-register write also clears the transmit-empty interrupt. When the FIFOs are enabled and the four low enable bits are all zero, the block is in polled mode: it reports nothing and never raises the line.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the enable register is 0x00, the status byte reads 0x01 (bit 0 = 1 means no interrupt) and `irq` is low.
- R2: Status bits [5:0] encode the selected source, from highest to lowest priority: line error 0x06, receive data 0x04, receive time-out 0x0C, transmit empty 0x02, modem change 0x00, software flow 0x10, hardware flow 0x20, none 0x01. Bits [7:6] both equal `fifo_en`.
- R3: Enable bit positions: bit 0 = receive data and time-out, bit 1 = transmit empty, bit 2 = line error, bit 3 = modem change, bit 5 = software flow, bit 6 = RTS rise, bit 7 = CTS rise. Bit 4 has no effect. A source whose enable is 0 is never reported.
- R4: The transmit-empty interrupt is latched one clock after (`thr_empty` and enable bit 1) goes from 0 to 1. Enabling bit 1 while the holding register is empty therefore raises it. A `thr_wr` pulse, or `thr_empty` going low, clears it at the next edge.
- R5: A status read clears the pending transmit-empty interrupt only when the status byte read in that cycle shows 0x02 in bits [5:0].
- R6: A rising CTS input with bit 7 set, or a rising RTS output with bit 6 set, latches the hardware flow source (0x20). A status read that reports it clears it. A rise that occurs while its enable bit is 0 is dropped.
- R7: An `xoff_det` or `spec_det` pulse with bit 5 set latches the software flow source (0x10). A status read that reports it clears it, unless a new event arrives in the same cycle.
- R8: With `fifo_en` = 1 and enable bits [3:0] = 0, the status byte reads 0xC1 and `irq` stays low, whatever is pending. Latched events are kept and appear once polled mode ends.
- R9: `irq` is high exactly when `out_en` is 1 and status bit 0 is 0.
- R10: Line-error, receive data, time-out and modem sources follow their inputs in the same cycle, and a status read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Enable register write data |
| fifo_en | input | 1 | FIFO mode enabled |
| out_en | input | 1 | Interrupt output gate from modem control |
| lsr_err | input | 1 | Line-status error pending (level) |
| rx_trig | input | 1 | Receive data at trigger level (level) |
| rx_tmo | input | 1 | Receive time-out (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_wr | input | 1 | Holding register write pulse |
| msr_chg | input | 1 | Modem status change pending (level) |
| xoff_det | input | 1 | Received Xoff character pulse |
| spec_det | input | 1 | Special character match pulse |
| cts_in | input | 1 | CTS input pin state |
| rts_out | input | 1 | RTS output pin state |
| isr_rd | input | 1 | Status register read pulse |
| isr_val | output | 8 | Status byte for the current cycle |
| irq | output | 1 | Interrupt output |

## Verification
The bench targets the cycle in which enabling the transmit-empty source while the holding register is already empty raises it. A design that detects only rising `thr_empty` would never raise it. It also checks a status read taken while a higher source hides the transmit-empty one; a design that clears on every read would lose that interrupt. Other cases: flow events that arrive during polled mode must survive until it ends, flow edges that arrive while masked must be dropped, and `irq` must follow `out_en`. Randomized traffic then mixes reads, writes and events against a model of the requirements, which catches priority swaps and clearing of level sources.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int IE_W   = 8;
    localparam int IE_RXD = 0;
    localparam int IE_THR = 1;
    localparam int IE_LSR = 2;
    localparam int IE_MSR = 3;
    localparam int IE_SWF = 5;
    localparam int IE_RTS = 6;
    localparam int IE_CTS = 7;

    localparam int NUM_SRC = 7;

    // Values follow priority order: lower value wins.
    typedef enum logic [2:0] {
        SRC_LSR  = 3'd0,
        SRC_RXD  = 3'd1,
        SRC_RXT  = 3'd2,
        SRC_THR  = 3'd3,
        SRC_MSR  = 3'd4,
        SRC_SWF  = 3'd5,
        SRC_HWF  = 3'd6,
        SRC_NONE = 3'd7
    } src_e;

    typedef struct packed {
        logic hwf;
        logic swf;
        logic msr;
        logic thr;
        logic rxt;
        logic rxd;
        logic lsr;
    } pend_t;

    function automatic logic [5:0] isr_code(src_e s);
        case (s)
            SRC_LSR: return 6'h06;
            SRC_RXD: return 6'h04;
            SRC_RXT: return 6'h0C;
            SRC_THR: return 6'h02;
            SRC_MSR: return 6'h00;
            SRC_SWF: return 6'h10;
            SRC_HWF: return 6'h20;
            default: return 6'h01;
        endcase
    endfunction

    function automatic logic is_polled(logic [IE_W-1:0] ier, logic fifo_en);
        return fifo_en && (ier[3:0] == 4'h0);
    endfunction

endpackage

// File: rtl/uirq_rise_det.sv
module uirq_rise_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Reset to ones so a pin already high at reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/uirq_event_latch.sv
module uirq_event_latch #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EV-1:0] ev,
    input  logic [N_EV-1:0] en,
    input  logic            clr,
    output logic            flag
);
    logic hit;
    assign hit = |(ev & en);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r7_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(hit));
    a_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag);
endmodule

// File: rtl/uirq_thr_tracker.sv
module uirq_thr_tracker (
    input  logic clk,
    input  logic rst,
    input  logic empty,
    input  logic enable,
    input  logic wr,
    input  logic rd_clr,
    output logic pend
);
    logic arm, arm_q, set_c, clr_c;

    assign arm   = empty & enable;
    assign set_c = arm & ~arm_q;
    assign clr_c = wr | ~empty | rd_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            arm_q <= arm;
            if (clr_c)      pend <= 1'b0;
            else if (set_c) pend <= 1'b1;
        end
    end

    a_r4_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr |=> !pend);
    a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(empty && enable));
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> !pend);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pend_t           pend,
    input  logic [IE_W-1:0] ier,
    input  logic            fifo_en,
    output src_e            sel
);
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] grant;

    always_comb begin
        req[SRC_LSR] = pend.lsr & ier[IE_LSR];
        req[SRC_RXD] = pend.rxd & ier[IE_RXD];
        req[SRC_RXT] = pend.rxt & ier[IE_RXD];
        req[SRC_THR] = pend.thr & ier[IE_THR];
        req[SRC_MSR] = pend.msr & ier[IE_MSR];
        req[SRC_SWF] = pend.swf & ier[IE_SWF];
        req[SRC_HWF] = pend.hwf & (ier[IE_RTS] | ier[IE_CTS]);
        if (is_polled(ier, fifo_en)) req = '0;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        sel   = SRC_NONE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && !found) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                sel      = src_e'(3'(i));
            end
        end
    end

    a_r2_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    a_r2_top_wins: assert property (@(posedge clk) disable iff (rst)
        req[SRC_LSR] |-> (sel == SRC_LSR));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ier_wr,
    input  logic [7:0] ier_wdata,
    input  logic       fifo_en,
    input  logic       out_en,
    input  logic       lsr_err,
    input  logic       rx_trig,
    input  logic       rx_tmo,
    input  logic       thr_empty,
    input  logic       thr_wr,
    input  logic       msr_chg,
    input  logic       xoff_det,
    input  logic       spec_det,
    input  logic       cts_in,
    input  logic       rts_out,
    input  logic       isr_rd,
    output logic [7:0] isr_val,
    output logic       irq
);
    localparam int N_FLOW = 2;

    logic [IE_W-1:0] ier_q;
    logic            thr_pend;
    logic            swf_flag, hwf_flag;
    logic [1:0]      pin_rise;
    pend_t           pend;
    src_e            sel;

    always_ff @(posedge clk) begin
        if (rst)         ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata;
    end

    uirq_thr_tracker u_thr (
        .clk    (clk),
        .rst    (rst),
        .empty  (thr_empty),
        .enable (ier_q[IE_THR]),
        .wr     (thr_wr),
        .rd_clr (isr_rd && (sel == SRC_THR)),
        .pend   (thr_pend)
    );

    // pin_rise[1] = CTS, pin_rise[0] = RTS
    uirq_rise_det #(.W(2)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .sig  ({cts_in, rts_out}),
        .rise (pin_rise)
    );

    uirq_event_latch #(.N_EV(N_FLOW)) u_swf (
        .clk  (clk),
        .rst  (rst),
        .ev   ({spec_det, xoff_det}),
        .en   ({ier_q[IE_SWF], ier_q[IE_SWF]}),
        .clr  (isr_rd && (sel == SRC_SWF)),
        .flag (swf_flag)
    );

    uirq_event_latch #(.N_EV(N_FLOW)) u_hwf (
        .clk  (clk),
        .rst  (rst),
        .ev   (pin_rise),
        .en   ({ier_q[IE_CTS], ier_q[IE_RTS]}),
        .clr  (isr_rd && (sel == SRC_HWF)),
        .flag (hwf_flag)
    );

    always_comb begin
        pend.lsr = lsr_err;
        pend.rxd = rx_trig;
        pend.rxt = rx_tmo;
        pend.thr = thr_pend;
        pend.msr = msr_chg;
        pend.swf = swf_flag;
        pend.hwf = hwf_flag;
    end

    uirq_prio_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .ier     (ier_q),
        .fifo_en (fifo_en),
        .sel     (sel)
    );

    assign isr_val = {fifo_en, fifo_en, isr_code(sel)};
    assign irq     = out_en & (sel != SRC_NONE);

    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !irq);
    a_r8_polled_quiet: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && ier_q[3:0] == 4'h0) |-> (isr_val[0] && !irq));
    a_r3_lsr_masked: assert property (@(posedge clk) disable iff (rst)
        !ier_q[IE_LSR] |-> (isr_val[5:0] != 6'h06));
    a_r10_level_kept: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && lsr_err && ier_q[IE_LSR] && !ier_wr && !fifo_en
         && $stable(lsr_err)) |=> (!lsr_err || isr_val[5:0] == 6'h06));
endmodule

// File: tb/sim_uirq_ctrl.sv
module sim_uirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ier_wr = 0, fifo_en = 0, out_en = 1;
    logic [7:0] ier_wdata = 0;
    logic lsr_err = 0, rx_trig = 0, rx_tmo = 0, thr_empty = 0, thr_wr = 0;
    logic msr_chg = 0, xoff_det = 0, spec_det = 0, cts_in = 0, rts_out = 0, isr_rd = 0;
    logic [7:0] isr_val;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_ier;
    logic m_thr, m_arm_q, m_swf, m_hwf, m_cts_q, m_rts_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    uirq_ctrl u0 (
        .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .fifo_en(fifo_en), .out_en(out_en), .lsr_err(lsr_err), .rx_trig(rx_trig),
        .rx_tmo(rx_tmo), .thr_empty(thr_empty), .thr_wr(thr_wr), .msr_chg(msr_chg),
        .xoff_det(xoff_det), .spec_det(spec_det), .cts_in(cts_in), .rts_out(rts_out),
        .isr_rd(isr_rd), .isr_val(isr_val), .irq(irq)
    );

    function automatic logic [7:0] exp_isr();
        logic [5:0] c;
        if (fifo_en && m_ier[3:0] == 4'h0)        c = 6'h01;
        else if (lsr_err && m_ier[2])             c = 6'h06;
        else if (rx_trig && m_ier[0])             c = 6'h04;
        else if (rx_tmo && m_ier[0])              c = 6'h0C;
        else if (m_thr && m_ier[1])               c = 6'h02;
        else if (msr_chg && m_ier[3])             c = 6'h00;
        else if (m_swf && m_ier[5])               c = 6'h10;
        else if (m_hwf && (m_ier[6] || m_ier[7])) c = 6'h20;
        else                                      c = 6'h01;
        return {fifo_en, fifo_en, c};
    endfunction

    task automatic model_reset();
        m_ier = 0; m_thr = 0; m_arm_q = 0; m_swf = 0; m_hwf = 0;
        m_cts_q = 1; m_rts_q = 1;
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic [7:0] cur;
        logic arm, swf_hit, hwf_hit;
        cur = exp_isr();
        arm = thr_empty && m_ier[1];
        if (thr_wr || !thr_empty || (isr_rd && cur[5:0] == 6'h02)) m_thr = 0;
        else if (arm && !m_arm_q) m_thr = 1;
        m_arm_q = arm;
        swf_hit = (xoff_det || spec_det) && m_ier[5];
        if (swf_hit) m_swf = 1;
        else if (isr_rd && cur[5:0] == 6'h10) m_swf = 0;
        hwf_hit = (cts_in && !m_cts_q && m_ier[7]) || (rts_out && !m_rts_q && m_ier[6]);
        if (hwf_hit) m_hwf = 1;
        else if (isr_rd && cur[5:0] == 6'h20) m_hwf = 0;
        m_cts_q = cts_in;
        m_rts_q = rts_out;
        if (ier_wr) m_ier = ier_wdata;
    endtask

    // Inputs are set at a falling edge; compare, advance the model, cross the rising edge.
    task automatic step(string tag);
        #1;
        check8(tag, isr_val, exp_isr());
        check8(tag, {7'd0, irq}, {7'd0, out_en && !exp_isr()[0]});
        model_update();
        @(posedge clk);
        @(negedge clk);
        ier_wr = 0; thr_wr = 0; isr_rd = 0; xoff_det = 0; spec_det = 0;
    endtask

    task automatic wr_ier(logic [7:0] v, string tag);
        ier_wr = 1; ier_wdata = v;
        step(tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check8("R1 reset status", isr_val, 8'h01);
        check8("R1 reset irq", {7'd0, irq}, 8'h00);
        @(negedge clk);

        // R4: enabling with an empty holding register raises it
        thr_empty = 1;
        wr_ier(8'h02, "R4 enable");
        step("R4 arm");
        step("R4 raised");
        check8("R4 pending code", isr_val, 8'h02);
        thr_wr = 1;
        step("R4 write");
        check8("R4 cleared by write", isr_val, 8'h01);
        thr_empty = 0; step("R4 refill");
        thr_empty = 1; step("R4 empty again");
        check8("R4 re-raised", isr_val, 8'h02);
        isr_rd = 1; step("R5 read reports thr");
        check8("R5 cleared by read", isr_val, 8'h01);

        // R5: masked by a higher source, a read must not clear it
        thr_empty = 0; step("R5 setup");
        wr_ier(8'h07, "R5 setup");
        thr_empty = 1; step("R5 setup");
        lsr_err = 1; step("R2 lsr over thr");
        isr_rd = 1; step("R5 read shows lsr");
        check8("R10 lsr level kept", isr_val, 8'h06);
        lsr_err = 0; step("R5 thr survives");
        check8("R5 thr still pending", isr_val, 8'h02);
        rx_tmo = 1; step("R2 timeout over thr");
        rx_trig = 1; step("R2 data over timeout");
        isr_rd = 1; step("R10 rx level kept");
        rx_trig = 0; rx_tmo = 0; thr_wr = 1; step("R4 clear");

        // R8: polled mode holds events back
        fifo_en = 1;
        wr_ier(8'h20, "R8 polled");
        xoff_det = 1; step("R8 event in polled");
        step("R8 polled quiet");
        check8("R8 polled status", isr_val, 8'hC1);
        check8("R8 polled irq", {7'd0, irq}, 8'h00);
        fifo_en = 0; step("R7 appears after polled");
        check8("R7 swf code", isr_val, 8'h10);
        out_en = 0; step("R9 gate off");
        check8("R9 irq gated", {7'd0, irq}, 8'h00);
        out_en = 1;
        isr_rd = 1; step("R7 read clears");
        check8("R7 cleared", isr_val, 8'h01);
        spec_det = 1; step("R7 special char");

        // R6: CTS/RTS rising edges
        isr_rd = 1; step("R7 clear");
        wr_ier(8'h80, "R6 cts enable");
        rts_out = 1; step("R6 rts masked");
        cts_in = 1; step("R6 cts rise");
        check8("R6 hwf code", isr_val, 8'h20);
        isr_rd = 1; step("R6 read clears");
        check8("R6 cleared", isr_val, 8'h01);
        wr_ier(8'h50, "R3 bit4 and rts");
        rts_out = 0; step("R6 rts low");
        rts_out = 1; step("R6 rts rise");
        check8("R6 rts code", isr_val, 8'h20);
        msr_chg = 1; wr_ier(8'h08, "R3 modem only");
        check8("R3 modem reported", isr_val, 8'h00);
        msr_chg = 0;

        // randomized traffic against the model
        for (int i = 0; i < 2000; i++) begin
            lsr_err   = ($urandom % 6) == 0;
            rx_trig   = ($urandom % 5) == 0;
            rx_tmo    = ($urandom % 7) == 0;
            msr_chg   = ($urandom % 6) == 0;
            thr_empty = ($urandom % 3) != 0;
            thr_wr    = ($urandom % 8) == 0;
            xoff_det  = ($urandom % 10) == 0;
            spec_det  = ($urandom % 12) == 0;
            cts_in    = ($urandom % 2) == 0;
            rts_out   = ($urandom % 2) == 0;
            isr_rd    = ($urandom % 3) == 0;
            fifo_en   = ($urandom % 4) == 0;
            out_en    = ($urandom % 6) != 0;
            ier_wr    = ($urandom % 9) == 0;
            ier_wdata = 8'($urandom);
            step("R2 R3 R10 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule